// File: doc/BRIEF.md
# Descending Stack Pointer Controller

This block keeps the pointer of a hardware stack that grows from the top of a RAM toward address zero. It turns push and pop requests into write and read cycles on an external synchronous RAM. Each accepted push writes the offered word. Each accepted pop issues a read, and the word comes back on the pop-data pins one cycle later. Status pins show whether the stack is empty or full. A one-cycle error pulse marks a request that was refused.

A parameter picks the pointer convention at elaboration. In "last full" mode the pointer addresses the most recently written word. A push first steps the pointer down and then writes at the new pointer. A pop reads at the pointer and then steps it up. In "next empty" mode the pointer addresses the free slot below the top of stack. A push writes at the pointer and then steps it down. A pop steps the pointer up and then reads there. Both modes use the same RAM locations for the same stack contents; only the pointer value differs. Each operation finishes in one clock, so the pointer step and the RAM access happen in the same cycle. The order between them shows up as which address is put on the bus.

Pushes enter over a valid/ready handshake. A word is taken in any cycle where `push_valid` and `push_ready` are both high, and `push_ready` is low exactly while the stack is full. The pop result has no back-pressure: `pop_valid` is a single-cycle strobe, and the consumer must take `pop_data` in that cycle. `pop_req` is a plain control pin.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, `sp` is 2**ADDR_W in last-full mode (LAST_FULL=1) and 2**ADDR_W-1 in next-empty mode (LAST_FULL=0). After reset `empty`=1, `full`=0, `pop_valid`=0 and `err`=0.
- R2: In last-full mode an accepted push drives `mem_we`=1, `mem_wdata`=`push_data` and `mem_addr`=`sp`-1 in that cycle, and `sp` is one lower after the clock edge.
- R3: In last-full mode an accepted pop drives `mem_we`=0 and `mem_addr`=`sp` in that cycle, and `sp` is one higher after the clock edge.
- R4: In next-empty mode an accepted push drives `mem_we`=1 and `mem_addr`=`sp` in that cycle, and `sp` is one lower after the clock edge. Because `sp` is ADDR_W+1 bits wide, a full stack leaves it at all ones.
- R5: In next-empty mode an accepted pop drives `mem_addr`=`sp`+1 in that cycle, and `sp` is one higher after the clock edge.
- R6: `pop_valid` is high for exactly the one cycle that follows each accepted pop, and at no other time. In that cycle `pop_data` is the RAM word read, so values come back in last-in first-out order.
- R7: `full` is high when 2**ADDR_W words are held and `empty` is high when none are held. `push_ready` equals the inverse of `full`.
- R8: A push offered while full is ignored: no write happens and `sp` does not change. `err` is high for the one cycle after that request.
- R9: A pop requested while empty, with no push offered, is ignored: no read strobe and no pointer change. `err` is high for the one cycle after that request.
- R10: When `push_valid` and `pop_req` are high in the same cycle, only the push is considered. The pop is dropped, and `pop_valid` stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push word offered |
| push_ready | output | 1 | Push can be taken (not full) |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Request to pop the top word |
| pop_valid | output | 1 | Pop result strobe, one cycle after the pop |
| pop_data | output | DATA_W | Popped word, valid with `pop_valid` |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, registered one cycle after the address |
| sp | output | ADDR_W+1 | Current stack pointer |
| empty | output | 1 | Stack holds no words |
| full | output | 1 | Stack holds 2**ADDR_W words |
| err | output | 1 | Pulse: previous request was refused |

## Verification
Push and pop can be requested in the same cycle. This is provoked three ways: on an empty stack, on a partly filled stack, and on a full stack where the push itself is refused. In each case the bench checks that the pointer moved only as a push would move it, or did not move at all when full. It also checks that no `pop_valid` strobe followed. On the full stack it checks that `err` flags the refused push. A pop that follows later must return the word the push wrote, which shows the dropped pop did not consume an entry.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_REJECT = 2'd3
  } stk_op_e;
endpackage

// File: rtl/stk_arbiter.sv
module stk_arbiter
  import stk_pkg::*;
(
  input  logic    push_valid,
  input  logic    pop_req,
  input  logic    full,
  input  logic    empty,
  output stk_op_e op
);
  // Push has priority; a pop is only looked at when no push is offered.
  always_comb begin
    op = OP_IDLE;
    if (push_valid) begin
      op = full ? OP_REJECT : OP_PUSH;
    end else if (pop_req) begin
      op = empty ? OP_REJECT : OP_POP;
    end
  end
endmodule

// File: rtl/stk_pointer.sv
module stk_pointer
  import stk_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter bit LAST_FULL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  output logic [ADDR_W:0]   sp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              full,
  output logic              empty
);
  localparam int SP_W  = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [SP_W-1:0] SP_RST = LAST_FULL ? SP_W'(DEPTH) : SP_W'(DEPTH - 1);

  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] cnt_q;
  logic [SP_W-1:0] push_loc;
  logic [SP_W-1:0] pop_loc;

  // The convention decides which side of the pointer step the access sits on.
  generate
    if (LAST_FULL) begin : g_last_full
      assign push_loc = sp_q - 1'b1;   // step down, then write
      assign pop_loc  = sp_q;          // read, then step up
    end else begin : g_next_empty
      assign push_loc = sp_q;          // write, then step down
      assign pop_loc  = sp_q + 1'b1;   // step up, then read
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= SP_RST;
      cnt_q <= '0;
    end else begin
      case (op)
        OP_PUSH: begin
          sp_q  <= sp_q - 1'b1;
          cnt_q <= cnt_q + 1'b1;
        end
        OP_POP: begin
          sp_q  <= sp_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (op == OP_PUSH) mem_addr = push_loc[ADDR_W-1:0];
    else               mem_addr = pop_loc[ADDR_W-1:0];
  end

  assign sp    = sp_q;
  assign full  = (cnt_q == SP_W'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/stk_rdpipe.sv
module stk_rdpipe
  import stk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  stk_op_e op,
  output logic    pop_valid,
  output logic    err
);
  // Matches the one-cycle read latency of the RAM.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      pop_valid <= (op == OP_POP);
      err       <= (op == OP_REJECT);
    end
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stk_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter bit LAST_FULL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W:0]   sp,
  output logic              empty,
  output logic              full,
  output logic              err
);
  stk_op_e op;

  stk_arbiter u_arb (
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .full       (full),
    .empty      (empty),
    .op         (op)
  );

  stk_pointer #(
    .ADDR_W    (ADDR_W),
    .LAST_FULL (LAST_FULL)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .sp       (sp),
    .mem_addr (mem_addr),
    .full     (full),
    .empty    (empty)
  );

  stk_rdpipe u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .pop_valid (pop_valid),
    .err       (err)
  );

  assign push_ready = ~full;
  assign mem_we     = (op == OP_PUSH);
  assign mem_wdata  = push_data;
  assign pop_data   = mem_rdata;
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int ADDR_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push_valid,
  input logic            pop_req,
  input logic            pop_valid,
  input logic            mem_we,
  input logic [ADDR_W:0] sp,
  input logic            empty,
  input logic            full,
  input logic            err
);
  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !full) |=> (sp == $past(sp) - 1'b1));
  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_valid && !empty) |=> (sp == $past(sp) + 1'b1));
  // R6
  pop_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_valid && !empty) |=> pop_valid);
  // R6
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_req && !push_valid && !empty) |=> !pop_valid);
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R8
  full_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !mem_we);
  // R8
  push_full_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full) |=> (err && $stable(sp)));
  // R9
  pop_empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_valid && empty) |=> (err && $stable(sp)));
  // R10
  push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_req) |=> !pop_valid);
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .pop_req    (pop_req),
  .pop_valid  (pop_valid),
  .mem_we     (mem_we),
  .sp         (sp),
  .empty      (empty),
  .full       (full),
  .err        (err)
);

// File: tb/stack_ptr_unit_tb_top.sv
`timescale 1ns/100ps
module stack_ptr_unit_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NV = 10;

  typedef struct packed {
    logic          push;
    logic          pop;
    logic [DW-1:0] data;
    logic          chk_addr;
    logic          we;
    logic [AW-1:0] addr;
    logic [AW:0]   sp;
    logic          err;
    logic          pv;
    logic [DW-1:0] pd;
  } vec_t;

  // Expected sp is for last-full; next-empty is one lower.
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 8'hA1, 1'b1, 1'b1, 4'd15, 5'd15, 1'b0, 1'b0, 8'h00},
    '{1'b1, 1'b0, 8'hB2, 1'b1, 1'b1, 4'd14, 5'd14, 1'b0, 1'b0, 8'h00},
    '{1'b1, 1'b1, 8'hC3, 1'b1, 1'b1, 4'd13, 5'd13, 1'b0, 1'b0, 8'h00},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 4'd13, 5'd14, 1'b0, 1'b1, 8'hC3},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 4'd14, 5'd15, 1'b0, 1'b1, 8'hB2},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 4'd15, 5'd16, 1'b0, 1'b1, 8'hA1},
    '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 4'd0,  5'd16, 1'b1, 1'b0, 8'h00},
    '{1'b1, 1'b0, 8'hD4, 1'b1, 1'b1, 4'd15, 5'd15, 1'b0, 1'b0, 8'h00},
    '{1'b1, 1'b0, 8'hE5, 1'b1, 1'b1, 4'd14, 5'd14, 1'b0, 1'b0, 8'h00},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 4'd14, 5'd15, 1'b0, 1'b1, 8'hE5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic pop_req = 1'b0;
  logic [DW-1:0] push_data = '0;

  // last-full instance signals
  logic          a_rdy, a_pv, a_we, a_empty, a_full, a_err;
  logic [DW-1:0] a_pd, a_wd, a_rd;
  logic [AW-1:0] a_addr;
  logic [AW:0]   a_sp;
  // next-empty instance signals
  logic          b_rdy, b_pv, b_we, b_empty, b_full, b_err;
  logic [DW-1:0] b_pd, b_wd, b_rd;
  logic [AW-1:0] b_addr;
  logic [AW:0]   b_sp;

  logic [DW-1:0] ram_a [1<<AW];
  logic [DW-1:0] ram_b [1<<AW];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  stack_ptr_unit #(.ADDR_W(AW), .DATA_W(DW), .LAST_FULL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(a_rdy),
    .push_data(push_data), .pop_req(pop_req), .pop_valid(a_pv), .pop_data(a_pd),
    .mem_addr(a_addr), .mem_we(a_we), .mem_wdata(a_wd), .mem_rdata(a_rd),
    .sp(a_sp), .empty(a_empty), .full(a_full), .err(a_err)
  );

  stack_ptr_unit #(.ADDR_W(AW), .DATA_W(DW), .LAST_FULL(1'b0)) dut_ne_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(b_rdy),
    .push_data(push_data), .pop_req(pop_req), .pop_valid(b_pv), .pop_data(b_pd),
    .mem_addr(b_addr), .mem_we(b_we), .mem_wdata(b_wd), .mem_rdata(b_rd),
    .sp(b_sp), .empty(b_empty), .full(b_full), .err(b_err)
  );

  always_ff @(posedge clk) begin
    if (a_we) ram_a[a_addr] <= a_wd;
    a_rd <= ram_a[a_addr];
    if (b_we) ram_b[b_addr] <= b_wd;
    b_rd <= ram_b[b_addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic pu, input logic po, input logic [DW-1:0] d);
    @(negedge clk);
    push_valid = pu;
    pop_req    = po;
    push_data  = d;
    #1;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic check_reset();
    chk(a_sp == 5'd16, "R1 lf sp", a_sp, 16);
    chk(b_sp == 5'd15, "R1 ne sp", b_sp, 15);
    chk(a_empty && b_empty, "R1 empty", a_empty, 1);
    chk(!a_full && !b_full, "R1 full", a_full, 0);
    chk(!a_pv && !b_pv, "R1 pop_valid", a_pv, 0);
    chk(!a_err && !b_err, "R1 err", a_err, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].push, TBL[i].pop, TBL[i].data);
      chk(a_we == TBL[i].we && b_we == TBL[i].we, "R2 R8 R9 we", a_we, TBL[i].we);
      if (TBL[i].we) begin
        chk(a_wd == TBL[i].data, "R2 wdata", a_wd, TBL[i].data);
        chk(a_addr == TBL[i].addr, "R2 lf push addr", a_addr, TBL[i].addr);
        chk(b_addr == TBL[i].addr, "R4 ne push addr", b_addr, TBL[i].addr);
      end else if (TBL[i].chk_addr) begin
        chk(a_addr == TBL[i].addr, "R3 lf pop addr", a_addr, TBL[i].addr);
        chk(b_addr == TBL[i].addr, "R5 ne pop addr", b_addr, TBL[i].addr);
      end
      settle();
      chk(a_sp == TBL[i].sp, "R2 R3 lf sp", a_sp, TBL[i].sp);
      chk(b_sp == TBL[i].sp - 5'd1, "R4 R5 ne sp", b_sp, TBL[i].sp - 5'd1);
      chk(a_err == TBL[i].err && b_err == TBL[i].err, "R9 err", a_err, TBL[i].err);
      chk(a_pv == TBL[i].pv && b_pv == TBL[i].pv, "R6 R10 pop_valid", a_pv, TBL[i].pv);
      if (TBL[i].pv) begin
        chk(a_pd == TBL[i].pd, "R6 lf pop_data", a_pd, TBL[i].pd);
        chk(b_pd == TBL[i].pd, "R6 ne pop_data", b_pd, TBL[i].pd);
      end
    end

    // Fill to full: one word (D4) is held, push 15 more.
    for (int k = 0; k < 15; k++) begin
      drive(1'b1, 1'b0, DW'(8'h10 + k));
      chk(a_addr == AW'(14 - k), "R2 fill addr", a_addr, 14 - k);
      settle();
    end
    drive(1'b0, 1'b0, '0);
    chk(a_full && b_full, "R7 full", a_full, 1);
    chk(!a_rdy && !b_rdy, "R7 push_ready", a_rdy, 0);
    chk(a_sp == 5'd0, "R2 lf sp full", a_sp, 0);
    chk(b_sp == 5'd31, "R4 ne sp full", b_sp, 31);

    // Push while full
    drive(1'b1, 1'b0, 8'hEE);
    chk(!a_we && !b_we, "R8 no write", a_we, 0);
    settle();
    chk(a_err && b_err, "R8 err", a_err, 1);
    chk(a_sp == 5'd0 && b_sp == 5'd31, "R8 sp held", a_sp, 0);
    drive(1'b0, 1'b0, '0);
    settle();
    chk(!a_err, "R8 err one cycle", a_err, 0);

    // Push and pop together while full
    drive(1'b1, 1'b1, 8'hEF);
    settle();
    chk(a_err, "R10 full err", a_err, 1);
    chk(!a_pv && !b_pv, "R10 pop dropped", a_pv, 0);
    chk(a_sp == 5'd0, "R10 sp held", a_sp, 0);

    // Drain: last-in first-out
    for (int k = 14; k >= 0; k--) begin
      drive(1'b0, 1'b1, '0);
      settle();
      chk(a_pv && a_pd == DW'(8'h10 + k), "R6 drain lf", a_pd, 8'h10 + k);
      chk(b_pv && b_pd == DW'(8'h10 + k), "R6 drain ne", b_pd, 8'h10 + k);
    end
    drive(1'b0, 1'b1, '0);
    settle();
    chk(a_pd == 8'hD4 && a_pv, "R6 last word", a_pd, 8'hD4);
    drive(1'b0, 1'b0, '0);
    chk(a_empty && b_empty, "R7 empty", a_empty, 1);
    chk(a_sp == 5'd16 && b_sp == 5'd15, "R3 R5 sp home", a_sp, 16);
    settle();
    chk(!a_pv, "R6 single strobe", a_pv, 0);

    // Pop while empty
    drive(1'b0, 1'b1, '0);
    settle();
    chk(a_err && b_err, "R9 empty err", a_err, 1);
    chk(!a_pv && a_sp == 5'd16, "R9 ignored", a_sp, 16);

    // Push and pop together on empty stack, then read back
    drive(1'b1, 1'b1, 8'h5A);
    settle();
    chk(!a_pv && !a_err, "R10 push wins empty", a_pv, 0);
    chk(a_sp == 5'd15, "R10 sp", a_sp, 15);
    drive(1'b0, 1'b1, '0);
    settle();
    chk(a_pv && a_pd == 8'h5A, "R10 word kept", a_pd, 8'h5A);

    // Reset in mid-use
    drive(1'b1, 1'b0, 8'h77);
    settle();
    drive(1'b0, 1'b0, '0);
    rst_n = 1'b0;
    settle();
    check_reset();
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule